// File: doc/BRIEF.md
# BCD Calendar Counter with Carry Flag

This block is a real-time-clock core. A tick strobe from a slow reference (128 per second by default) feeds a prescaler. The prescaler's count is visible as a sub-second byte. Each time the prescaler wraps, a chain of packed-BCD counters advances: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Day of month follows the month length, and February gains a 29th day in years divisible by four.

Software reaches the core through a byte-wide register port and reads the registers one at a time, so a read sequence can straddle a seconds carry. To catch this, the core raises a carry flag on every seconds carry. Software clears the flag before a read sequence and checks it afterwards. If the flag is set again, the values may be torn and software reads them again. The flag can also drive an interrupt. A second control register starts and stops counting, gates the clock, and clears the prescaler.

Top module: `rtc_cal_core`

## Requirements
- R1: After synchronous reset, the registers read as follows. Sub-second, seconds, minutes, hours and weekday are 0. Day and month are 0x01 and year is 0x00. Both control registers are 0, so counting is stopped, and `carry_irq_o` is 0.
- R2: A read returns its data on `bus_rdata_o` one clock after `bus_addr_i` is presented. The address map is: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year, 14 control A, 15 control B. Addresses 8 to 13 read 0 and ignore writes. The sub-second register ignores writes.
- R3: While running, each clock with `tick_i` high advances the prescaler. The sub-second register reads the prescaler count, 0 to TICK_HZ-1, in its low bits. The count wraps to 0 on tick number TICK_HZ, and that wrap advances seconds by one.
- R4: Control A bit 7 is the carry flag. It is set by every seconds advance. Writing control A with bit 7 at 0 clears it, and writing 1 leaves it unchanged. If a seconds advance and a clearing write fall in the same clock, the flag ends up set.
- R5: Control A bit 4 is the carry interrupt enable. `carry_irq_o` is high, one clock later, while both the flag and the enable are 1.
- R6: Seconds and minutes wrap from 0x59 to 0x00. Hours wrap from 0x23 to 0x00. Weekday steps on each day change and wraps from 6 to 0.
- R7: Counting is frozen unless control B bit 0 (start) and bit 3 (enable) are both 1. Writing control B with bit 1 at 1 clears the prescaler. Bit 1 reads back 0, and control B reads back {4'b0, enable, 2'b0, start}.
- R8: Day wraps to 0x01 after the last day of the month: 31, 30 for months 04, 06, 09 and 11, or 28 or 29 for month 02. This advances the month. Month wraps from 0x12 to 0x01 and advances the year. Year wraps from 0x99 to 0x00.
- R9: February has 29 days when the BCD year is divisible by 4, including 00.
- R10: A write to any calendar register loads the written value on that clock, whether or not counting runs. A write wins over an advance in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock strobe from the reference, TICK_HZ per second |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Registered read data for the address of the previous clock |
| carry_irq_o | output | 1 | Carry interrupt, flag AND enable |

## Verification
The hardest case to reach is a clearing write to control A landing in exactly the clock where the prescaler wraps. A related case is a counter write colliding with an advance. The bench counts the prescaler up to its last value, then drives the tick and the write in the same clock. Month-end, leap-year and year-end rollovers would take simulated days to reach from reset. The bench instead stops the core, loads times one second before those boundaries, and restarts it. Random dates biased toward field maxima are compared against a calendar model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_AW  = 4;
  localparam int NFIELD  = 7;   // sec, min, hour, wday, day, month, year
  localparam int DAY_IDX = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_SUBSEC = 4'd0,
    RA_SEC    = 4'd1,
    RA_MIN    = 4'd2,
    RA_HOUR   = 4'd3,
    RA_WDAY   = 4'd4,
    RA_DAY    = 4'd5,
    RA_MON    = 4'd6,
    RA_YEAR   = 4'd7,
    RA_CTRL_A = 4'd14,
    RA_CTRL_B = 4'd15
  } reg_addr_e;

  // Packed-BCD increment without range check.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] bcd_month_len(input logic [7:0] mon,
                                               input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_lo(input int idx);
    return (idx == 4 || idx == 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] field_hi(input int idx);
    case (idx)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h06;
      4:       return 8'h31;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter  int TICK_HZ = 128,
  localparam int PRE_W   = $clog2(TICK_HZ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [PRE_W-1:0] count_o,
  output logic             sec_step_o
);

  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_HZ - 1);

  logic adv;
  assign adv        = tick_i && run_i && !clr_i;
  assign sec_step_o = adv && (count_o == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i)   count_o <= '0;
    else if (adv)       count_o <= (count_o == LAST) ? '0 : count_o + 1'b1;
  end

endmodule

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr #(
  parameter logic [7:0] LO = 8'h00,
  parameter logic [7:0] HI = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o
);
  import rtc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)         val_o <= LO;
    else if (we_i)   val_o <= wdata_i;
    else if (step_i) val_o <= (val_o == HI) ? LO : bcd_inc(val_o);
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sec_step_i,
  input  logic [NFIELD-1:0]      we_i,
  input  logic [7:0]             wdata_i,
  output logic [NFIELD-1:0][7:0] val_o
);

  // Weekday sits in the chain but does not gate the day carry.
  localparam logic [NFIELD-1:0] PASS = 7'b0001000;

  logic [NFIELD-1:0] at_max;
  logic [NFIELD-1:0] gate;
  logic [NFIELD-1:0] step;

  assign at_max[NFIELD-1] = 1'b0;
  assign gate = PASS | at_max;

  always_comb begin
    logic acc;
    acc = sec_step_i;
    for (int i = 0; i < NFIELD; i++) begin
      step[i] = acc;
      acc     = acc & gate[i];
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    if (g == DAY_IDX) begin : g_day
      logic [7:0] last_day;
      logic [7:0] day_q;
      assign last_day  = bcd_month_len(val_o[DAY_IDX+1], val_o[DAY_IDX+2]);
      assign at_max[g] = (day_q == last_day);
      assign val_o[g]  = day_q;
      always_ff @(posedge clk) begin
        if (rst)          day_q <= 8'h01;
        else if (we_i[g]) day_q <= wdata_i;
        else if (step[g]) day_q <= at_max[g] ? 8'h01 : bcd_inc(day_q);
      end
    end else begin : g_ctr
      rtc_bcd_ctr #(
        .LO(field_lo(g)),
        .HI(field_hi(g))
      ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .step_i (step[g]),
        .we_i   (we_i[g]),
        .wdata_i(wdata_i),
        .val_o  (val_o[g])
      );
      if (g < NFIELD-1) begin : g_max
        assign at_max[g] = (val_o[g] == field_hi(g));
      end
    end
  end

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_pkg::*;
#(
  parameter  int TICK_HZ = 128,
  localparam int PRE_W   = $clog2(TICK_HZ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              carry_irq_o
);

  logic                   start_q, en_q, cf_q, cie_q;
  logic                   run, presc_clr, sec_step;
  logic                   wr_ctl_a, wr_ctl_b;
  logic [PRE_W-1:0]       presc_cnt;
  logic [NFIELD-1:0]      field_we;
  logic [NFIELD-1:0][7:0] cal_val;

  assign run       = start_q & en_q;
  assign wr_ctl_a  = bus_we_i && (bus_addr_i == RA_CTRL_A);
  assign wr_ctl_b  = bus_we_i && (bus_addr_i == RA_CTRL_B);
  assign presc_clr = wr_ctl_b && bus_wdata_i[1];

  always_comb begin
    for (int i = 0; i < NFIELD; i++)
      field_we[i] = bus_we_i && (bus_addr_i == REG_AW'(i + 1));
  end

  rtc_prescaler #(.TICK_HZ(TICK_HZ)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .run_i     (run),
    .clr_i     (presc_clr),
    .count_o   (presc_cnt),
    .sec_step_o(sec_step)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst       (rst),
    .sec_step_i(sec_step),
    .we_i      (field_we),
    .wdata_i   (bus_wdata_i),
    .val_o     (cal_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      en_q    <= 1'b0;
      cf_q    <= 1'b0;
      cie_q   <= 1'b0;
    end else begin
      if (wr_ctl_b) begin
        start_q <= bus_wdata_i[0];
        en_q    <= bus_wdata_i[3];
      end
      if (wr_ctl_a) cie_q <= bus_wdata_i[4];
      if (sec_step)                          cf_q <= 1'b1;
      else if (wr_ctl_a && !bus_wdata_i[7])  cf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= 8'h00;
      carry_irq_o <= 1'b0;
    end else begin
      carry_irq_o <= cf_q & cie_q;
      case (bus_addr_i)
        RA_SUBSEC: bus_rdata_o <= 8'(presc_cnt);
        RA_SEC:    bus_rdata_o <= cal_val[0];
        RA_MIN:    bus_rdata_o <= cal_val[1];
        RA_HOUR:   bus_rdata_o <= cal_val[2];
        RA_WDAY:   bus_rdata_o <= cal_val[3];
        RA_DAY:    bus_rdata_o <= cal_val[4];
        RA_MON:    bus_rdata_o <= cal_val[5];
        RA_YEAR:   bus_rdata_o <= cal_val[6];
        RA_CTRL_A: bus_rdata_o <= {cf_q, 2'b00, cie_q, 4'h0};
        RA_CTRL_B: bus_rdata_o <= {4'h0, en_q, 2'b00, start_q};
        default:   bus_rdata_o <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk #(
  parameter int PRE_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_step,
  input logic             run,
  input logic             presc_clr,
  input logic [PRE_W-1:0] presc_cnt,
  input logic             cf_q,
  input logic             cie_q,
  input logic             carry_irq,
  input logic [7:0]       sec_bcd,
  input logic [7:0]       hour_bcd
);

  assert_step_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    sec_step |-> run);

  assert_carry_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    sec_step |=> cf_q);

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (carry_irq == $past(cf_q && cie_q)));

  assert_sec_range_R6: assert property (@(posedge clk) disable iff (rst)
    (sec_bcd <= 8'h59) && (sec_bcd[3:0] <= 4'd9));

  assert_hour_range_R6: assert property (@(posedge clk) disable iff (rst)
    hour_bcd <= 8'h23);

  assert_frozen_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !presc_clr) |=> $stable(presc_cnt));

endmodule

bind rtc_cal_core rtc_cal_chk #(.PRE_W(PRE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sec_step (sec_step),
  .run      (run),
  .presc_clr(presc_clr),
  .presc_cnt(presc_cnt),
  .cf_q     (cf_q),
  .cie_q    (cie_q),
  .carry_irq(carry_irq_o),
  .sec_bcd  (cal_val[0]),
  .hour_bcd (cal_val[2])
);

// File: tb/rtc_cal_core_tb.sv
`timescale 1ns/1ps
module rtc_cal_core_tb;
  localparam int HZ = 128;

  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench calendar model (binary)
  int ms = 0, mmi = 0, mh = 0, mwd = 0, md = 1, mm = 1, my = 0, mpre = 0;

  always #2 clk = ~clk;

  rtc_cal_core #(.TICK_HZ(HZ)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .carry_irq_o(irq)
  );

  function automatic logic [7:0] b2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_of(input int a);
    case (a)
      1: return b2b(ms);  2: return b2b(mmi); 3: return b2b(mh);
      4: return b2b(mwd); 5: return b2b(md);  6: return b2b(mm);
      default: return b2b(my);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic model_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mmi++;
      if (mmi == 60) begin
        mmi = 0; mh++;
        if (mh == 24) begin
          mh = 0; mwd = (mwd + 1) % 7;
          if (md == mdim(mm, my)) begin
            md = 1;
            if (mm == 12) begin mm = 1; my = (my + 1) % 100; end
            else mm++;
          end else md++;
        end
      end
    end
  endtask

  task automatic model_tick();
    mpre++;
    if (mpre == HZ) begin mpre = 0; model_sec(); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    @(posedge clk); #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input bit running);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (running) model_tick();
    end
    tick = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int a = 1; a <= 7; a++) begin
      rd(4'(a), v);
      chk(tag, v, exp_of(a));
    end
  endtask

  task automatic set_time(input int y, input int m, input int d, input int h,
                          input int mi, input int s, input int wd);
    wr(4'd15, 8'h02);   // stop and clear prescaler
    wr(4'd1, b2b(s)); wr(4'd2, b2b(mi)); wr(4'd3, b2b(h)); wr(4'd4, b2b(wd));
    wr(4'd5, b2b(d)); wr(4'd6, b2b(m));  wr(4'd7, b2b(y));
    ms = s; mmi = mi; mh = h; mwd = wd; md = d; mm = m; my = y; mpre = 0;
    wr(4'd15, 8'h09);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'd0, v); chk("R1 subsec", v, 8'h00);
    check_all("R1 calendar");
    rd(4'd14, v); chk("R1 ctrlA", v, 8'h00);
    rd(4'd15, v); chk("R1 ctrlB", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R7 stopped after reset
    ticks(5, 1'b0);
    rd(4'd0, v); chk("R7 stopped subsec", v, 8'h00);

    // R3 prescaler counting, R7 readback
    wr(4'd15, 8'h09);
    rd(4'd15, v); chk("R7 ctrlB readback", v, 8'h09);
    ticks(10, 1'b1);
    rd(4'd0, v); chk("R3 subsec count", v, 8'd10);

    // R7 enable low freezes
    wr(4'd15, 8'h01);
    ticks(4, 1'b0);
    rd(4'd0, v); chk("R7 enable off", v, 8'd10);

    // R7 prescaler clear, reset bit reads 0
    wr(4'd15, 8'h0B); mpre = 0;
    rd(4'd0, v); chk("R7 presc clear", v, 8'h00);
    rd(4'd15, v); chk("R7 clear bit reads 0", v, 8'h09);

    // R3 full second, R4 flag set, R5 irq off without enable
    ticks(HZ, 1'b1);
    rd(4'd0, v); chk("R3 subsec wrap", v, 8'h00);
    rd(4'd1, v); chk("R3 seconds advance", v, 8'h01);
    rd(4'd14, v); chk("R4 flag set", v, 8'h80);
    chk("R5 irq masked", {7'd0, irq}, 8'h00);

    // R5 enable, then R4 clear
    wr(4'd14, 8'h90);
    @(negedge clk);
    chk("R5 irq asserted", {7'd0, irq}, 8'h01);
    rd(4'd14, v); chk("R4 write 1 keeps flag", v, 8'h90);
    wr(4'd14, 8'h10);
    @(negedge clk);
    chk("R5 irq cleared", {7'd0, irq}, 8'h00);
    rd(4'd14, v); chk("R4 flag cleared", v, 8'h10);

    // R4 set wins over a same-clock clear
    ticks(HZ - 1, 1'b1);
    tick = 1'b1; we = 1'b1; addr = 4'd14; wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; we = 1'b0; model_tick();
    rd(4'd14, v); chk("R4 set wins", v, 8'h90);
    wr(4'd14, 8'h10);

    // R10 write beats advance, and write while running
    ticks(HZ - 1, 1'b1);
    tick = 1'b1; we = 1'b1; addr = 4'd1; wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; we = 1'b0; model_tick(); ms = 10;
    check_all("R10 write beats advance");
    wr(4'd1, 8'h45); ms = 45;
    rd(4'd1, v); chk("R10 write while running", v, 8'h45);

    // R2 alarm space ignored, sub-second read-only
    wr(4'd9, 8'h55);
    rd(4'd9, v); chk("R2 alarm reads 0", v, 8'h00);
    wr(4'd0, 8'h33);
    rd(4'd0, v); chk("R2 subsec read-only", v, 8'(mpre));
    check_all("R2 calendar untouched");

    // R6/R8/R9 directed rollovers
    set_time(24, 2, 28, 23, 59, 59, 6); ticks(HZ, 1'b1);
    check_all("R9 leap feb");
    rd(4'd5, v); chk("R9 feb 29", v, 8'h29);
    rd(4'd4, v); chk("R6 weekday wrap", v, 8'h00);
    set_time(23, 2, 28, 23, 59, 59, 2); ticks(HZ, 1'b1);
    rd(4'd6, v); chk("R9 non-leap to march", v, 8'h03);
    set_time(0, 2, 28, 23, 59, 59, 2); ticks(HZ, 1'b1);
    rd(4'd5, v); chk("R9 year 00 leap", v, 8'h29);
    set_time(99, 12, 31, 23, 59, 59, 5); ticks(HZ, 1'b1);
    check_all("R8 year end");
    rd(4'd7, v); chk("R8 year wrap", v, 8'h00);
    set_time(7, 4, 30, 23, 59, 59, 1); ticks(HZ, 1'b1);
    check_all("R8 30 day month");

    // random dates biased toward rollover
    for (int it = 0; it < 30; it++) begin
      int y, m, d, h, mi, s, wd, n;
      y  = $urandom % 100;
      m  = 1 + $urandom % 12;
      d  = ($urandom % 2) ? mdim(m, y) : 1 + $urandom % mdim(m, y);
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      wd = $urandom % 7;
      n  = 1 + $urandom % 2;
      set_time(y, m, d, h, mi, s, wd);
      ticks(n * HZ, 1'b1);
      check_all("R6 R8 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule